// File: doc/BRIEF.md
# Adaptive Critical-Word Placement Predictor

This block sits between a last-level cache and a split memory system made of a small low-latency memory and a larger low-power memory. Each cache line is eight words long. On every fill, only one of those words is stored in the fast memory, and the other seven go to the slow memory. The block chooses which word goes in the fast memory so that the word a core asks for first is likely to come back quickly.

For each cache slot the block keeps a 3-bit history of the word that was requested first in the most recent demand access. When a dirty line is written back, that history is used as the prediction for the line's next critical word. The block then emits the line split into one fast word and seven slow words. It also records the chosen index in a per-memory-line placement table. On a later miss, the fetch logic reads that table through a lookup port. This tells the fast request which word to fetch and the slow request which seven words to fetch. A clean eviction writes nothing back, so the stored layout in memory stays valid and is left unchanged.

Top module: `crit_word_predictor`

## Requirements
- R1: After reset, every history entry and every placement entry is word index 0, and both `wb_valid_o` and `lkup_valid_o` are low.
- R2: A demand access with `acc_valid_i` high stores `acc_word_i` as the history of slot `acc_slot_i`. The most recent access to a slot wins.
- R3: A dirty eviction (`evict_valid_i` and `evict_dirty_i` high) raises `wb_valid_o` for exactly the next cycle. In that cycle `wb_line_o` carries the evicted memory line and `wb_fast_idx_o` carries the history of the evicted slot.
- R4: `wb_fast_word_o` equals the word at the predicted index of the evicted data. Word k of `evict_data_i` occupies bits [k*WORD_W +: WORD_W].
- R5: `wb_slow_words_o` holds the other seven words in ascending index order with the fast word removed. Slow position j occupies bits [j*WORD_W +: WORD_W], so for j below the fast index it is word j, and otherwise it is word j+1.
- R6: A dirty eviction records its fast index in the placement entry of `evict_line_i`. Lookups issued from the next cycle on return that index.
- R7: A clean eviction produces no writeback and leaves the placement entry of its line unchanged.
- R8: A lookup with `lkup_valid_i` high returns, one cycle later, `lkup_valid_o` high with the line's stored fast index. `lkup_slow_mask_o` then has bit k set for every word k except the fast one.
- R9: When an access and a dirty eviction hit the same slot in the same cycle, the eviction uses the history stored before that cycle, and the access takes effect afterwards.
- R10: When a lookup and a dirty eviction hit the same memory line in the same cycle, the lookup returns the placement stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Demand access strobe |
| acc_slot_i | input | SLOT_W | Cache slot accessed |
| acc_word_i | input | IDX_W | Index of the word requested first |
| evict_valid_i | input | 1 | Eviction strobe |
| evict_slot_i | input | SLOT_W | Cache slot being evicted |
| evict_line_i | input | LINE_W | Memory line address of the evicted line |
| evict_dirty_i | input | 1 | Evicted line is dirty |
| evict_data_i | input | WORDS*WORD_W | Evicted line data, word k at bits k*WORD_W |
| wb_valid_o | output | 1 | Writeback output valid |
| wb_line_o | output | LINE_W | Memory line being written back |
| wb_fast_idx_o | output | IDX_W | Index of the word sent to fast memory |
| wb_fast_word_o | output | WORD_W | Word sent to fast memory |
| wb_slow_words_o | output | (WORDS-1)*WORD_W | Remaining words in ascending index order |
| lkup_valid_i | input | 1 | Fetch-routing lookup strobe |
| lkup_line_i | input | LINE_W | Memory line to look up |
| lkup_valid_o | output | 1 | Lookup response valid |
| lkup_fast_idx_o | output | IDX_W | Stored fast-word index of the line |
| lkup_slow_mask_o | output | WORDS | Words to fetch from slow memory |

## Verification
Several properties are checked by assertions on every cycle. A clean eviction never produces a writeback. Every writeback's fast word is the evicted word at its own index. Every placement write lands in the table, and every writeback's index is already present in the placement table. Every lookup is answered one cycle later with a mask that clears exactly the fast word.

Other behaviour can only be shown by the bench's scenarios. These are that the prediction follows the most recent access, the order of the seven slow words, the same-cycle collisions on a slot or a line, and that a clean eviction leaves an earlier layout in place.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  // source word index for slow position j when word fast_idx is removed
  function automatic int unsigned slow_src(int unsigned j, int unsigned fast_idx);
    return (j < fast_idx) ? j : j + 1;
  endfunction
endpackage

// File: rtl/cwp_meta_table.sv
module cwp_meta_table #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 3,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // read returns contents before a same-cycle write
  assign rd_data_o = mem_q[rd_addr_i];

  p_write_lands_r2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/cwp_permute.sv
module cwp_permute #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic [WORDS*WORD_W-1:0]     line_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [WORD_W-1:0]           fast_o,
  output logic [(WORDS-1)*WORD_W-1:0] slow_o
);
  assign fast_o = line_i[idx_i*WORD_W +: WORD_W];

  for (genvar j = 0; j < WORDS - 1; j++) begin : g_slow
    assign slow_o[j*WORD_W +: WORD_W] = (IDX_W'(j) < idx_i)
      ? line_i[j*WORD_W +: WORD_W]
      : line_i[(j+1)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/crit_word_predictor.sv
module crit_word_predictor #(
  parameter int WORD_W    = 32,
  parameter int WORDS     = 8,
  parameter int NUM_SLOTS = 64,
  parameter int NUM_LINES = 256,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_valid_i,
  input  logic [SLOT_W-1:0]           acc_slot_i,
  input  logic [IDX_W-1:0]            acc_word_i,
  input  logic                        evict_valid_i,
  input  logic [SLOT_W-1:0]           evict_slot_i,
  input  logic [LINE_W-1:0]           evict_line_i,
  input  logic                        evict_dirty_i,
  input  logic [WORDS*WORD_W-1:0]     evict_data_i,
  output logic                        wb_valid_o,
  output logic [LINE_W-1:0]           wb_line_o,
  output logic [IDX_W-1:0]            wb_fast_idx_o,
  output logic [WORD_W-1:0]           wb_fast_word_o,
  output logic [(WORDS-1)*WORD_W-1:0] wb_slow_words_o,
  input  logic                        lkup_valid_i,
  input  logic [LINE_W-1:0]           lkup_line_i,
  output logic                        lkup_valid_o,
  output logic [IDX_W-1:0]            lkup_fast_idx_o,
  output logic [WORDS-1:0]            lkup_slow_mask_o
);
  logic                        wb_fire;
  logic [IDX_W-1:0]            pred_idx;
  logic [IDX_W-1:0]            place_idx;
  logic [WORD_W-1:0]           fast_word;
  logic [(WORDS-1)*WORD_W-1:0] slow_words;

  assign wb_fire = evict_valid_i & evict_dirty_i;

  // cache-side history: last critical word per slot
  cwp_meta_table #(.DEPTH(NUM_SLOTS), .DATA_W(IDX_W)) u_hist_tbl (
    .clk_i, .rst_ni,
    .wr_en_i  (acc_valid_i),
    .wr_addr_i(acc_slot_i),
    .wr_data_i(acc_word_i),
    .rd_addr_i(evict_slot_i),
    .rd_data_o(pred_idx)
  );

  // memory-side layout: fast word index per memory line
  cwp_meta_table #(.DEPTH(NUM_LINES), .DATA_W(IDX_W)) u_place_tbl (
    .clk_i, .rst_ni,
    .wr_en_i  (wb_fire),
    .wr_addr_i(evict_line_i),
    .wr_data_i(pred_idx),
    .rd_addr_i(lkup_line_i),
    .rd_data_o(place_idx)
  );

  cwp_permute #(.WORD_W(WORD_W), .WORDS(WORDS)) u_permute (
    .line_i(evict_data_i),
    .idx_i (pred_idx),
    .fast_o(fast_word),
    .slow_o(slow_words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o      <= 1'b0;
      wb_line_o       <= '0;
      wb_fast_idx_o   <= '0;
      wb_fast_word_o  <= '0;
      wb_slow_words_o <= '0;
    end else begin
      wb_valid_o <= wb_fire;
      if (wb_fire) begin
        wb_line_o       <= evict_line_i;
        wb_fast_idx_o   <= pred_idx;
        wb_fast_word_o  <= fast_word;
        wb_slow_words_o <= slow_words;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkup_valid_o     <= 1'b0;
      lkup_fast_idx_o  <= '0;
      lkup_slow_mask_o <= '0;
    end else begin
      lkup_valid_o <= lkup_valid_i;
      if (lkup_valid_i) begin
        lkup_fast_idx_o  <= place_idx;
        lkup_slow_mask_o <= ~(WORDS'(1) << place_idx);
      end
    end
  end

  p_clean_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && !evict_dirty_i) |=> !wb_valid_o);

  p_fast_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_fire |=> wb_fast_word_o == WORD_W'($past(evict_data_i) >> (wb_fast_idx_o * WORD_W)));

  p_layout_recorded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> u_place_tbl.mem_q[wb_line_o] == wb_fast_idx_o);

  p_lkup_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_valid_i |=> lkup_valid_o);

  p_slow_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_valid_o |-> ($countones(lkup_slow_mask_o) == WORDS - 1
                      && !lkup_slow_mask_o[lkup_fast_idx_o]));
endmodule

// File: tb/crit_word_predictor_tb_top.sv
module crit_word_predictor_tb_top;
  localparam int WORD_W = 32, WORDS = 8, NUM_SLOTS = 64, NUM_LINES = 256;
  localparam int IDX_W = 3, SLOT_W = 6, LINE_W = 8;
  localparam int LW = WORDS * WORD_W, SW = (WORDS - 1) * WORD_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic acc_v = 0, ev_v = 0, ev_dirty = 0, lk_v = 0;
  logic [SLOT_W-1:0] acc_slot = 0, ev_slot = 0;
  logic [IDX_W-1:0]  acc_word = 0;
  logic [LINE_W-1:0] ev_line = 0, lk_line = 0;
  logic [LW-1:0]     ev_data = 0;
  logic wb_v, lk_vo;
  logic [LINE_W-1:0] wb_line;
  logic [IDX_W-1:0]  wb_idx, lk_idx;
  logic [WORD_W-1:0] wb_fast;
  logic [SW-1:0]     wb_slow;
  logic [WORDS-1:0]  lk_mask;

  crit_word_predictor #(.WORD_W(WORD_W), .WORDS(WORDS), .NUM_SLOTS(NUM_SLOTS),
                        .NUM_LINES(NUM_LINES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_v), .acc_slot_i(acc_slot), .acc_word_i(acc_word),
    .evict_valid_i(ev_v), .evict_slot_i(ev_slot), .evict_line_i(ev_line),
    .evict_dirty_i(ev_dirty), .evict_data_i(ev_data),
    .wb_valid_o(wb_v), .wb_line_o(wb_line), .wb_fast_idx_o(wb_idx),
    .wb_fast_word_o(wb_fast), .wb_slow_words_o(wb_slow),
    .lkup_valid_i(lk_v), .lkup_line_i(lk_line),
    .lkup_valid_o(lk_vo), .lkup_fast_idx_o(lk_idx), .lkup_slow_mask_o(lk_mask)
  );

  typedef struct {
    logic [LINE_W-1:0] line;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] fast;
    logic [SW-1:0]     slow;
    string             tag;
  } wb_exp_t;
  typedef struct {
    logic [IDX_W-1:0] idx;
    logic [WORDS-1:0] mask;
    string            tag;
  } lk_exp_t;

  wb_exp_t wb_q[$];
  lk_exp_t lk_q[$];
  logic [IDX_W-1:0] hist_m  [NUM_SLOTS];
  logic [IDX_W-1:0] place_m [NUM_LINES];
  int checks = 0, errors = 0;

  task automatic check(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] make_line(int seed);
    logic [LW-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*WORD_W +: WORD_W] = {seed[23:0], 8'(k)};
    return l;
  endfunction

  // driver: one cycle of stimulus, expectations from the model state before it
  task automatic step(bit a, int as, int aw, bit e, int es, int el, bit d,
                      logic [LW-1:0] data, bit l, int ll, string tag);
    @(negedge clk);
    acc_v = a; acc_slot = SLOT_W'(as); acc_word = IDX_W'(aw);
    ev_v = e; ev_slot = SLOT_W'(es); ev_line = LINE_W'(el); ev_dirty = d; ev_data = data;
    lk_v = l; lk_line = LINE_W'(ll);
    if (l) begin
      lk_exp_t x;
      x.idx = place_m[ll]; x.mask = ~(WORDS'(1) << place_m[ll]); x.tag = tag;
      lk_q.push_back(x);
    end
    if (e && d) begin
      wb_exp_t w;
      int p;
      p = int'(hist_m[es]);
      w.line = LINE_W'(el); w.idx = IDX_W'(p);
      w.fast = data[p*WORD_W +: WORD_W]; w.tag = tag;
      for (int j = 0; j < WORDS - 1; j++)
        w.slow[j*WORD_W +: WORD_W] = data[((j < p) ? j : j + 1)*WORD_W +: WORD_W];
      wb_q.push_back(w);
      place_m[el] = IDX_W'(p);
    end
    if (a) hist_m[as] = IDX_W'(aw);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, '0, 0, 0, "idle");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_v) begin
        if (wb_q.size() == 0) check(0, "R7 unexpected writeback", 1, 0);
        else begin
          wb_exp_t w;
          w = wb_q.pop_front();
          check(wb_line == w.line, {w.tag, " R3 line"}, 256'(wb_line), 256'(w.line));
          check(wb_idx == w.idx, {w.tag, " R3 fast index"}, 256'(wb_idx), 256'(w.idx));
          check(wb_fast == w.fast, {w.tag, " R4 fast word"}, 256'(wb_fast), 256'(w.fast));
          check(wb_slow == w.slow, {w.tag, " R5 slow order"}, 256'(wb_slow), 256'(w.slow));
        end
      end
      if (lk_vo) begin
        if (lk_q.size() == 0) check(0, "R8 unexpected lookup response", 1, 0);
        else begin
          lk_exp_t x;
          x = lk_q.pop_front();
          check(lk_idx == x.idx, {x.tag, " R8 lookup index"}, 256'(lk_idx), 256'(x.idx));
          check(lk_mask == x.mask, {x.tag, " R8 slow mask"}, 256'(lk_mask), 256'(x.mask));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_SLOTS; i++) hist_m[i] = '0;
    for (int i = 0; i < NUM_LINES; i++) place_m[i] = '0;
    repeat (3) @(negedge clk);
    check(!wb_v && !lk_vo, "R1 outputs idle in reset", 256'({wb_v, lk_vo}), 0);
    rst_n = 1'b1;
    // R1: empty history and placement read as word 0
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 255, "R1");
    step(0, 0, 0, 1, 3, 10, 1, make_line(1), 1, 77, "R1");
    // R2: last access wins
    step(1, 3, 5, 0, 0, 0, 0, '0, 0, 0, "R2");
    step(1, 3, 2, 0, 0, 0, 0, '0, 0, 0, "R2");
    step(0, 0, 0, 1, 3, 10, 1, make_line(2), 0, 0, "R2");
    // R6: lookup sees recorded index
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 10, "R6");
    // R7: clean eviction keeps layout
    step(1, 3, 7, 0, 0, 0, 0, '0, 0, 0, "R7");
    step(0, 0, 0, 1, 3, 10, 0, make_line(3), 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 10, "R7");
    // R4 R5: every index, including both ends
    for (int k = 0; k < WORDS; k++) step(1, 16 + k, k, 0, 0, 0, 0, '0, 0, 0, "R4");
    for (int k = 0; k < WORDS; k++) step(0, 0, 0, 1, 16 + k, 20 + k, 1, make_line(40 + k), 1, 20 + k, "R5");
    for (int k = 0; k < WORDS; k++) step(0, 0, 0, 0, 0, 0, 0, '0, 1, 20 + k, "R8");
    // R9: same-cycle access and eviction on one slot
    step(1, 9, 1, 0, 0, 0, 0, '0, 0, 0, "R9");
    step(1, 9, 6, 1, 9, 50, 1, make_line(60), 0, 0, "R9");
    step(0, 0, 0, 1, 9, 51, 1, make_line(61), 0, 0, "R9");
    // R10: same-cycle lookup and writeback on one line
    step(1, 12, 4, 0, 0, 0, 0, '0, 0, 0, "R10");
    step(0, 0, 0, 1, 12, 30, 1, make_line(70), 1, 30, "R10");
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 30, "R10");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom);
      step(r[0], r[6:1], r[9:7], r[10], r[13:11], r[18:14], r[19], make_line(r),
           r[20], r[25:21], "mix R3");
    end
    idle(3);
    check(wb_q.size() == 0 && lk_q.size() == 0, "R3 R8 missing responses",
          256'(wb_q.size() + lk_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule